// File: doc/BRIEF.md
# Block-Length FIFO Interrupt Controller

This block buffers bytes between an 8-bit processor bus and a serial engine. It has two 4-entry FIFOs: one carries bytes from the host to the serial transmitter, and one carries bytes from the serial receiver to the host. The host is not interrupted on every character. A programmable block length and a small set of buffer events decide when the single active-low interrupt line is pulled.

On the receive side, a block counter counts the bytes the FIFO accepts. When it reaches the block length it reports an end of block and reloads to zero. The receive FIFO going full is a second reason to interrupt, so blocks longer than the FIFO can be drained in pieces. On the transmit side, the interrupt fires when the serial engine pops the last byte and the FIFO is left empty, so the host can refill it.

Each interrupt source has its own two-state machine with the states `PEND_IDLE` and `PEND_RAISED`. The transitions are:
- **raise**: `PEND_IDLE` to `PEND_RAISED` when the source's event fires.
- **hold**: stays in `PEND_RAISED` while no clear arrives, or when an event and a clear arrive in the same cycle.
- **clear**: `PEND_RAISED` to `PEND_IDLE` on a clear with no event.

A status read clears both sources. A host FIFO access clears the source it belongs to: a write clears transmit, a read clears receive.

Top module: `blk_fifo_irq`

## Requirements
- R1: Each FIFO stores exactly 4 bytes and returns them in arrival order. The `*_full` flag is 1 at 4 entries and the `*_empty` flag is 1 at 0 entries. A write to a full transmit FIFO and a pop of an empty FIFO have no effect.
- R2: With `blk_len` from 1 to 3, `irq_n` goes to 0 on the clock edge that accepts the receive byte completing the block, and not before. The sticky flag `rx_eob` is set on that same edge.
- R3: With `blk_len` above 4, `irq_n` goes to 0 on the edge at which the receive FIFO becomes full, without setting `rx_eob`. It goes to 0 again on the edge that accepts the final byte of the block, and `rx_eob` is set then.
- R4: `irq_n` goes to 0 on the edge at which a serial pop leaves the transmit FIFO empty, provided no host write happens in the same cycle.
- R5: `irq_n` is 0 exactly when `tx_src` or `rx_src` is 1. Both source flags are registered.
- R6: `ser_rx_err` is stored with its byte. A byte marked in error is still accepted, and `host_rerr` shows its mark while that byte is at the head of the receive FIFO.
- R7: `stat_rd` clears `tx_src`, `rx_src`, `rx_eob` and `rx_ovr`. `host_rd` clears `rx_src`, and `host_wr` clears `tx_src`. When a set and a clear arrive in the same cycle, the set wins.
- R8: A receive push while the receive FIFO is full is dropped and sets the sticky flag `rx_ovr`. The stored bytes are unchanged.
- R9: The block counter reloads to zero at each end of block, so the next block again takes `blk_len` bytes. A `blk_len` of 0 behaves as 1.
- R10: A synchronous `rst` empties both FIFOs, clears all flags and the block counter, and drives `irq_n` to 1.
- R11: A push and a pop in the same cycle on one FIFO both take effect. The entry count stays the same, and no full or empty event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_len | input | 8 | Receive block length (0 behaves as 1) |
| host_wr | input | 1 | Host writes `host_wdata` into the transmit FIFO |
| host_wdata | input | 8 | Host transmit byte |
| host_rd | input | 1 | Host pops the receive FIFO head |
| host_rdata | output | 8 | Receive FIFO head byte |
| host_rerr | output | 1 | Error mark of the receive FIFO head byte |
| stat_rd | input | 1 | Host status read; clears pending sources and sticky flags |
| ser_tx_pop | input | 1 | Serial engine takes the transmit FIFO head |
| ser_tx_data | output | 8 | Transmit FIFO head byte |
| ser_rx_push | input | 1 | Serial engine delivers a received byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_err | input | 1 | Received byte had a parity or framing error |
| irq_n | output | 1 | Interrupt, active low |
| tx_src | output | 1 | Transmit-empty interrupt pending |
| rx_src | output | 1 | Receive interrupt pending |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_eob | output | 1 | Sticky: a receive block has completed |
| rx_ovr | output | 1 | Sticky: a receive byte was dropped |

## Verification
The receive interrupt is tried with three kinds of block length:
- Lengths 1 and 3 show that the end of block alone raises the line.
- A length of 6 separates the fill event from the end-of-block event, because `rx_eob` stays 0 at the fill.
- A length of 0 exercises the "behaves as 1" rule.

The transmit interrupt is checked across a drain of the FIFO, and again with a host write landing in the same cycle as a pop. That second case shows that simultaneous traffic does not fake an empty event. A cycle where a new receive byte completes a block while the host reads shows the set-over-clear priority. Pushing into a full receive FIFO with a distinctive byte shows that the byte is dropped and not overwritten.

// File: rtl/blkirq_pkg.sv
package blkirq_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned FIFO_DEPTH = 4;
    localparam int unsigned LEN_W = 8;

    typedef enum logic {
        PEND_IDLE   = 1'b0,
        PEND_RAISED = 1'b1
    } pend_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && $stable(wptr)));
    p_pop_empty_r1: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (empty && $stable(rptr)));
    p_both_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> $stable(count));
endmodule

// File: rtl/blk_counter.sv
module blk_counter #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             step,
    output logic             eob
);
    logic [LEN_W-1:0] cnt;
    logic [LEN_W:0]   nxt;

    assign nxt = {1'b0, cnt} + 1'b1;
    // Reaching or passing the length ends the block; a length of 0 ends every byte.
    assign eob = step && (nxt >= {1'b0, blk_len});

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (eob)  cnt <= '0;
        else if (step) cnt <= nxt[LEN_W-1:0];
    end

    p_reload_r9: assert property (@(posedge clk) disable iff (rst)
        eob |=> (cnt == '0));
    p_advance_r9: assert property (@(posedge clk) disable iff (rst)
        (step && !eob) |=> (cnt != '0));
endmodule

// File: rtl/pend_fsm.sv
module pend_fsm
    import blkirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    pend_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= PEND_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PEND_IDLE:   if (set)        state_nxt = PEND_RAISED;
            PEND_RAISED: if (clr && !set) state_nxt = PEND_IDLE;
            default:     state_nxt = PEND_IDLE;
        endcase
    end

    always_comb begin
        pend = (state == PEND_RAISED);
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (pend && clr && !set) |=> !pend);
endmodule

// File: rtl/blk_fifo_irq.sv
module blk_fifo_irq
    import blkirq_pkg::*;
#(
    parameter int unsigned DW    = BYTE_W,
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned LW    = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] blk_len,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic          host_rerr,
    input  logic          stat_rd,
    input  logic          ser_tx_pop,
    output logic [DW-1:0] ser_tx_data,
    input  logic          ser_rx_push,
    input  logic [DW-1:0] ser_rx_data,
    input  logic          ser_rx_err,
    output logic          irq_n,
    output logic          tx_src,
    output logic          rx_src,
    output logic          tx_empty,
    output logic          tx_full,
    output logic          rx_empty,
    output logic          rx_full,
    output logic          rx_eob,
    output logic          rx_ovr
);
    localparam int unsigned CW     = $clog2(DEPTH + 1);
    localparam int unsigned N_SRC  = 2;
    localparam int unsigned SRC_TX = 0;
    localparam int unsigned SRC_RX = 1;

    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW:0]   rx_head;
    logic          blk_end, rx_fill_evt, tx_drain_evt;
    logic [N_SRC-1:0] src_set, src_clr, src_pend;

    byte_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(host_wr), .din(host_wdata),
        .pop(ser_tx_pop), .dout(ser_tx_data),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    byte_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(ser_rx_push), .din({ser_rx_err, ser_rx_data}),
        .pop(host_rd), .dout(rx_head),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    assign host_rdata = rx_head[DW-1:0];
    assign host_rerr  = rx_head[DW];

    blk_counter #(.LEN_W(LW)) u_blk (
        .clk(clk), .rst(rst), .blk_len(blk_len),
        .step(rx_push_ok), .eob(blk_end)
    );

    // Buffer events: count crosses into full (rx) or into empty (tx).
    assign rx_fill_evt  = rx_push_ok && !rx_pop_ok && (rx_cnt == CW'(DEPTH - 1));
    assign tx_drain_evt = tx_pop_ok && !tx_push_ok && (tx_cnt == CW'(1));

    assign src_set[SRC_TX] = tx_drain_evt;
    assign src_clr[SRC_TX] = stat_rd || host_wr;
    assign src_set[SRC_RX] = blk_end || rx_fill_evt;
    assign src_clr[SRC_RX] = stat_rd || host_rd;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        pend_fsm u_pend (
            .clk(clk), .rst(rst),
            .set(src_set[g]), .clr(src_clr[g]), .pend(src_pend[g])
        );
    end

    assign tx_src = src_pend[SRC_TX];
    assign rx_src = src_pend[SRC_RX];
    assign irq_n  = ~|src_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_eob <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            if (blk_end)      rx_eob <= 1'b1;
            else if (stat_rd) rx_eob <= 1'b0;
            if (ser_rx_push && rx_full) rx_ovr <= 1'b1;
            else if (stat_rd)           rx_ovr <= 1'b0;
        end
    end

    p_overrun_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_rx_push && rx_full) |=> rx_ovr);
    p_rx_fill_irq_r3: assert property (@(posedge clk) disable iff (rst)
        (ser_rx_push && !host_rd && rx_cnt == CW'(DEPTH - 1)) |=> !irq_n);
    p_tx_drain_irq_r4: assert property (@(posedge clk) disable iff (rst)
        (ser_tx_pop && !host_wr && tx_cnt == CW'(1)) |=> !irq_n);
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (irq_n && tx_empty && rx_empty && !rx_eob && !rx_ovr));
endmodule

// File: tb/tb_blk_fifo_irq.sv
module tb_blk_fifo_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] blk_len = 8'd1;
    logic       host_wr = 1'b0, host_rd = 1'b0, stat_rd = 1'b0;
    logic       ser_tx_pop = 1'b0, ser_rx_push = 1'b0, ser_rx_err = 1'b0;
    logic [7:0] host_wdata = '0, ser_rx_data = '0;
    logic [7:0] host_rdata, ser_tx_data;
    logic       host_rerr, irq_n, tx_src, rx_src;
    logic       tx_empty, tx_full, rx_empty, rx_full, rx_eob, rx_ovr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    blk_fifo_irq dut (
        .clk(clk), .rst(rst), .blk_len(blk_len),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .host_rerr(host_rerr),
        .stat_rd(stat_rd),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_err(ser_rx_err),
        .irq_n(irq_n), .tx_src(tx_src), .rx_src(rx_src),
        .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_eob(rx_eob), .rx_ovr(rx_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edge_end();
        @(posedge clk);
        #1;
        host_wr = 0; host_rd = 0; stat_rd = 0; ser_tx_pop = 0; ser_rx_push = 0; ser_rx_err = 0;
    endtask

    task automatic do_reset(input logic [7:0] len);
        @(negedge clk); rst = 1; blk_len = len;
        edge_end();
        @(negedge clk); rst = 0;
        #1;
    endtask

    task automatic do_wr(input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d; edge_end();
    endtask
    task automatic do_pop();
        @(negedge clk); ser_tx_pop = 1; edge_end();
    endtask
    task automatic do_wr_pop(input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d; ser_tx_pop = 1; edge_end();
    endtask
    task automatic do_push(input logic [7:0] d, input logic e);
        @(negedge clk); ser_rx_push = 1; ser_rx_data = d; ser_rx_err = e; edge_end();
    endtask
    task automatic do_rd();
        @(negedge clk); host_rd = 1; edge_end();
    endtask
    task automatic do_rd_push(input logic [7:0] d);
        @(negedge clk); host_rd = 1; ser_rx_push = 1; ser_rx_data = d; edge_end();
    endtask
    task automatic do_stat();
        @(negedge clk); stat_rd = 1; edge_end();
    endtask

    task automatic t_reset();
        do_reset(8'd1);
        chk("R10 irq_n", irq_n, 1);
        chk("R10 tx_empty", tx_empty, 1);
        chk("R10 rx_empty", rx_empty, 1);
        chk("R10 full flags", {tx_full, rx_full, rx_ovr, rx_eob}, 0);
        do_push(8'h11, 0);
        chk("R2 irq after push len1", irq_n, 0);
        do_reset(8'd1);
        chk("R10 irq cleared by reset", irq_n, 1);
        chk("R10 rx emptied by reset", rx_empty, 1);
    endtask

    task automatic t_tx();
        do_reset(8'd4);
        for (int i = 0; i < 4; i++) do_wr(8'hA0 + 8'(i));
        chk("R1 tx_full at 4", tx_full, 1);
        do_wr(8'hA4);
        chk("R1 tx_full after extra write", tx_full, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R1 tx order", ser_tx_data, 8'hA0 + 8'(i));
            if (i == 3) chk("R4 no irq before last pop", irq_n, 1);
            do_pop();
        end
        chk("R1 tx_empty after drain", tx_empty, 1);
        chk("R4 irq on drain", irq_n, 0);
        chk("R5 tx_src on drain", {tx_src, rx_src}, 2'b10);
        do_wr(8'hB0);
        chk("R7 host write clears tx_src", irq_n, 1);
        do_pop();
        chk("R4 irq on second drain", irq_n, 0);
        do_stat();
        chk("R7 status read clears tx_src", irq_n, 1);
        do_wr(8'hC0);
        do_wr_pop(8'hC1);
        chk("R11 tx not empty after wr+pop", tx_empty, 0);
        chk("R11 no drain irq on wr+pop", irq_n, 1);
        chk("R11 tx head after wr+pop", ser_tx_data, 8'hC1);
        do_pop();
        chk("R4 irq on drain after wr+pop", irq_n, 0);
    endtask

    task automatic t_rx_short();
        do_reset(8'd3);
        do_push(8'h11, 0);
        do_push(8'h22, 0);
        chk("R2 no irq before block end", irq_n, 1);
        do_push(8'h33, 0);
        chk("R2 irq at block end", irq_n, 0);
        chk("R2 rx_eob at block end", rx_eob, 1);
        chk("R1 rx head", host_rdata, 8'h11);
        do_rd();
        chk("R7 host read clears rx_src", irq_n, 1);
        chk("R7 rx_eob sticky", rx_eob, 1);
        chk("R1 rx second", host_rdata, 8'h22);
        do_rd(); do_rd();
        chk("R1 rx_empty", rx_empty, 1);
        do_stat();
        chk("R7 status read clears rx_eob", rx_eob, 0);
        do_push(8'h44, 0);
        do_push(8'h55, 0);
        chk("R9 no irq mid second block", irq_n, 1);
        do_push(8'h66, 0);
        chk("R9 irq at second block end", irq_n, 0);
    endtask

    task automatic t_rx_len1();
        do_reset(8'd1);
        do_push(8'h5A, 0);
        chk("R2 irq len1", irq_n, 0);
        do_rd();
        chk("R7 read clears", irq_n, 1);
        do_push(8'h5B, 0);
        chk("R2 irq len1 again", irq_n, 0);
        do_rd_push(8'h5C);
        chk("R7 set wins over read clear", irq_n, 0);
        chk("R11 rx head after rd+push", host_rdata, 8'h5C);
        chk("R11 rx not full", rx_full, 0);
    endtask

    task automatic t_rx_long();
        do_reset(8'd6);
        for (int i = 1; i <= 3; i++) do_push(8'(i), 0);
        chk("R3 no irq before full", irq_n, 1);
        do_push(8'd4, 0);
        chk("R3 irq at full", irq_n, 0);
        chk("R3 rx_full", rx_full, 1);
        chk("R3 no eob at full", rx_eob, 0);
        for (int i = 1; i <= 4; i++) begin
            chk("R1 rx order long", host_rdata, 8'(i));
            do_rd();
        end
        chk("R3 irq cleared by reads", irq_n, 1);
        do_push(8'd5, 0);
        chk("R3 no irq at byte 5", irq_n, 1);
        do_push(8'd6, 0);
        chk("R3 irq at block end", irq_n, 0);
        chk("R3 eob at block end", rx_eob, 1);
        do_stat();
        do_push(8'd7, 0);
        chk("R9 counter reloaded", irq_n, 1);
    endtask

    task automatic t_overrun();
        do_reset(8'd10);
        for (int i = 0; i < 4; i++) do_push(8'h70 + 8'(i), 0);
        do_push(8'hEE, 0);
        chk("R8 rx_ovr set", rx_ovr, 1);
        chk("R8 still full", rx_full, 1);
        for (int i = 0; i < 4; i++) begin
            chk("R8 contents unchanged", host_rdata, 8'h70 + 8'(i));
            do_rd();
        end
        chk("R8 empty after 4 reads", rx_empty, 1);
        chk("R8 rx_ovr sticky", rx_ovr, 1);
        do_stat();
        chk("R7 status read clears rx_ovr", rx_ovr, 0);
    endtask

    task automatic t_err_len0();
        do_reset(8'd10);
        do_push(8'h3C, 1);
        do_push(8'hC3, 0);
        chk("R6 err byte stored", host_rdata, 8'h3C);
        chk("R6 err mark", host_rerr, 1);
        do_rd();
        chk("R6 clean byte", {host_rerr, host_rdata}, 9'h0C3);
        do_reset(8'd0);
        do_push(8'h01, 0);
        chk("R9 len0 acts as 1", {irq_n, rx_eob}, 2'b01);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_tx();
        t_rx_short();
        t_rx_len1();
        t_rx_long();
        t_overrun();
        t_err_len0();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule